// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing controller of a small serial EEPROM. A fast system clock samples the two-wire bus lines SCL and SDA. The block detects START and STOP framing and decodes a control byte whose upper nibble identifies the device type. It then either accepts a word address followed by write data, or streams stored bytes back to the bus master. The block drives SDA only through an open-drain style output enable. The storage array sits outside the block behind a simple synchronous port that has one-cycle read latency. The array holds two or four banks of 256 bytes, and the `NUM_BANKS` parameter selects the count.

Incoming write data goes into a 16-entry page buffer that is indexed by the low address bits. A STOP then starts a self-timed programming cycle, which a cycle counter models. The buffered bytes are committed during that cycle. The block stays silent on the bus until the cycle has finished. A write-protect input blocks every change to the array.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A command begins only on a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, ends it. Bytes clocked without a preceding START get no acknowledge.
- R2: The block acknowledges the first byte after START only when its bits [7:4] equal 4'b1010. After any other code it sends no acknowledge for the rest of that command.
- R3: An acknowledge holds SDA low through the whole high phase of the ninth clock. SDA is released after the falling edge of that clock, and SDA changes only while SCL is low.
- R4: On a write, control bits [3:1] select the bank. Bit 3 is always ignored, and bit 2 is ignored when NUM_BANKS is 2. The used bits become the address bits above the 8-bit word address.
- R5: On a write, the second byte is the word address and later bytes are data. Each data byte goes to the current page offset, which is the low 4 address bits. The offset then increments and wraps within the 16-byte page. When more than 16 bytes arrive, only the last 16 are kept.
- R6: A STOP after at least one write data byte starts a programming cycle of PROG_CYCLES clocks. No acknowledge is given during that cycle, including for a valid control byte.
- R7: While wp is high, no array location is written. A write that ends while wp is high starts no programming cycle.
- R8: When control bit 0 is 1, a read follows. Bytes come from the address counter MSB first. The counter increments after each byte across the whole array and wraps from the top address to 0. The bank bits are ignored on a read.
- R9: A byte that the master does not acknowledge ends the read. The block leaves SDA released until the next START.
- R10: A repeated START inside a command restarts control-byte decoding and discards unwritten data. A write control byte plus word address followed by a read control byte therefore reads from that address.
- R11: A STOP after only the word address writes nothing and starts no programming cycle, but it keeps the address for later reads.
- R12: After reset the SDA output enable and the memory write enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Resolved level of the bus data line |
| sdaOe | output | 1 | High pulls the data line low |
| wp | input | 1 | Write protect, high blocks array writes |
| memAddr | output | 8+log2(NUM_BANKS) | Array address |
| memWrEn | output | 1 | Array write strobe |
| memWrData | output | 8 | Array write data |
| memRdData | input | 8 | Array read data, valid one cycle after memAddr |

## Verification
The block reacts to each SCL edge about three system clocks after that edge, which is the two synchronizer flops plus the edge register. The bench therefore changes SDA half of the low phase after a falling SCL edge and samples SDA in the middle of the high phase. Acknowledges and read bits are already settled at that point. Array writes fall in the first 16 clocks of the programming cycle. The bench polls for the busy silence within the first few hundred clocks after STOP. It compares the whole array model only after waiting more than PROG_CYCLES clocks.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ldBank;
    logic ldWord;
    logic bufPush;
    logic bufClear;
    logic progRun;
  } ctlStrobe_t;
endpackage

// File: rtl/eeprom_bus_sense.sv
module eeprom_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sda,
  output logic sdaNow,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], scl};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sda};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclSync[SYNC_STAGES-1];
  assign sdaNow    = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_slave_pkg::*;
#(
  parameter int BANK_W      = 1,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 5000,
  localparam int ADDR_W     = 8 + BANK_W,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W      = $clog2(PROG_CYCLES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              sdaBit,
  input  logic              wp,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic              bufAny,
  output logic              progDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);
  localparam logic [CNT_W-1:0] PAGE_LIM  = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PROG_CYCLES - 1);

  logic [7:0]            rxReg, txReg;
  logic [ADDR_W-1:0]     addrCnt;
  logic [7:0]            pageData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [CNT_W-1:0]      progCnt;
  logic [OFF_W-1:0]      pageOff, progIdx;
  logic                  inWindow;

  assign pageOff  = addrCnt[OFF_W-1:0];
  assign progIdx  = progCnt[OFF_W-1:0];
  assign inWindow = progCnt < PAGE_LIM;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg     <= '0;
      txReg     <= '1;
      addrCnt   <= '0;
      pageValid <= '0;
      progCnt   <= '0;
    end else begin
      if (ctl.rxShift) rxReg <= {rxReg[6:0], sdaBit};

      if (ctl.txLoad)       txReg <= memRdData;
      else if (ctl.txShift) txReg <= {txReg[6:0], 1'b1};

      if (ctl.txLoad)      addrCnt <= addrCnt + ADDR_W'(1);
      else if (ctl.ldBank) addrCnt[ADDR_W-1:8] <= rxReg[BANK_W:1];
      else if (ctl.ldWord) addrCnt[7:0] <= rxReg;
      else if (ctl.bufPush) addrCnt[OFF_W-1:0] <= pageOff + OFF_W'(1);

      if (ctl.bufClear)     pageValid <= '0;
      else if (ctl.bufPush) pageValid[pageOff] <= 1'b1;

      progCnt <= ctl.progRun ? progCnt + CNT_W'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufPush) pageData[pageOff] <= rxReg;
  end

  assign rxByte    = rxReg;
  assign txBit     = txReg[7];
  assign bufAny    = |pageValid;
  assign progDone  = progCnt == LAST_TICK;
  assign memAddr   = ctl.progRun ? {addrCnt[ADDR_W-1:OFF_W], progIdx} : addrCnt;
  assign memWrEn   = ctl.progRun & inWindow & pageValid[progIdx] & ~wp;
  assign memWrData = pageData[progIdx];
endmodule

// File: rtl/eeprom_control.sv
module eeprom_control
  import eeprom_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaNow,
  input  logic [3:0] ctlCode,
  input  logic       rwBit,
  input  logic       txBit,
  input  logic       bufAny,
  input  logic       progDone,
  input  logic       wp,
  output ctlStrobe_t ctl,
  output logic       sdaOe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT, ST_PROG
  } state_t;
  typedef enum logic [1:0] { PH_CTRL, PH_WORD, PH_DATA } phase_t;

  state_t st, stN;
  phase_t ph, phN;
  logic readMode, rdN, byteFull, fullN, mAck, mAckN;
  logic [2:0] bitCnt, bcN;

  always_comb begin
    stN = st; phN = ph; rdN = readMode; bcN = bitCnt;
    fullN = byteFull; mAckN = mAck; ctl = '0;
    if (st == ST_PROG) begin
      ctl.progRun = 1'b1;
      if (progDone) begin
        stN = ST_IDLE;
        ctl.bufClear = 1'b1;
      end
    end else if (startSeen) begin
      stN = ST_RX; phN = PH_CTRL; rdN = 1'b0; bcN = '0; fullN = 1'b0;
      ctl.bufClear = 1'b1;
    end else if (stopSeen) begin
      if (st != ST_IDLE && ph == PH_DATA && !readMode && bufAny && !wp) stN = ST_PROG;
      else begin
        stN = ST_IDLE;
        ctl.bufClear = 1'b1;
      end
      phN = PH_CTRL;
    end else begin
      case (st)
        ST_RX: begin
          if (sclRise) begin
            ctl.rxShift = 1'b1;
            bcN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) fullN = 1'b1;
          end else if (sclFall && byteFull) begin
            fullN = 1'b0;
            bcN = '0;
            case (ph)
              PH_CTRL: begin
                if (ctlCode == DEV_CODE) begin
                  stN = ST_ACK;
                  rdN = rwBit;
                  if (!rwBit) begin
                    ctl.ldBank = 1'b1;
                    phN = PH_WORD;
                  end
                end else stN = ST_WAIT;
              end
              PH_WORD: begin
                ctl.ldWord = 1'b1;
                phN = PH_DATA;
                stN = ST_ACK;
              end
              default: begin
                ctl.bufPush = 1'b1;
                stN = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bcN = '0;
            if (readMode) begin
              ctl.txLoad = 1'b1;
              stN = ST_TX;
            end else stN = ST_RX;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) stN = ST_MACK;
            else begin
              ctl.txShift = 1'b1;
              bcN = bitCnt + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) mAckN = ~sdaNow;
          else if (sclFall) begin
            if (mAck) begin
              ctl.txLoad = 1'b1;
              stN = ST_TX;
              bcN = '0;
            end else stN = ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; ph <= PH_CTRL; readMode <= 1'b0;
      bitCnt <= '0; byteFull <= 1'b0; mAck <= 1'b0;
    end else begin
      st <= stN; ph <= phN; readMode <= rdN;
      bitCnt <= bcN; byteFull <= fullN; mAck <= mAckN;
    end
  end

  assign sdaOe = (st == ST_ACK) | ((st == ST_TX) & ~txBit);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_slave_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2,
  localparam int BANK_W     = (NUM_BANKS > 2) ? 2 : 1,
  localparam int ADDR_W     = 8 + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              wp,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);
  ctlStrobe_t ctl;
  logic sdaNow, sclRise, sclFall, startSeen, stopSeen;
  logic txBit, bufAny, progDone;
  logic [7:0] rxByte;

  eeprom_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) uSense (
    .clk, .rstN, .scl, .sda(sdaIn), .sdaNow, .sclRise, .sclFall,
    .startSeen, .stopSeen
  );

  eeprom_control uCtl (
    .clk, .rstN, .sclRise, .sclFall, .startSeen, .stopSeen, .sdaNow,
    .ctlCode(rxByte[7:4]), .rwBit(rxByte[0]), .txBit, .bufAny, .progDone,
    .wp, .ctl, .sdaOe
  );

  eeprom_datapath #(
    .BANK_W(BANK_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
  ) uDp (
    .clk, .rstN, .ctl, .sdaBit(sdaNow), .wp, .rxByte, .txBit, .bufAny,
    .progDone, .memAddr, .memWrEn, .memWrData, .memRdData
  );
endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
  parameter int NUM_BANKS  = 2,
  parameter int PAGE_BYTES = 16,
  localparam int ADDR_W    = 8 + ((NUM_BANKS > 2) ? 2 : 1),
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              wp,
  input logic              sdaOe,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr
);
  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wp |-> !memWrEn); // R7
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !scl); // R3
  AST_SILENT_WHILE_PROG: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !sdaOe); // R6
  AST_PAGE_CONFINED: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |->
      (memAddr[ADDR_W-1:OFF_W] == $past(memAddr[ADDR_W-1:OFF_W]))); // R5
  AST_PAGE_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |->
      (memAddr[OFF_W-1:0] == $past(memAddr[OFF_W-1:0]) + OFF_W'(1))); // R5
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(
  .NUM_BANKS(NUM_BANKS), .PAGE_BYTES(PAGE_BYTES)
) uChk (
  .clk(clk), .rstN(rstN), .scl(scl), .wp(wp), .sdaOe(sdaOe),
  .memWrEn(memWrEn), .memAddr(memAddr)
);

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int PROG       = 300;
  localparam int ADDR_W     = 9;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaM = 1'b1, wp = 1'b0;
  logic sdaOe, memWrEn, sdaLine;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memWrData, memRdData;
  logic [7:0] mem [DEPTH];
  logic [7:0] expMem [DEPTH];
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  serial_eeprom_slave #(.NUM_BANKS(2), .PROG_CYCLES(PROG)) u0 (
    .clk, .rstN, .scl, .sdaIn(sdaLine), .sdaOe, .wp,
    .memAddr, .memWrEn, .memWrData, .memRdData
  );

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initVal(i);
      memRdData <= '0;
    end else begin
      if (memWrEn) mem[memAddr] <= memWrData;
      memRdData <= mem[memAddr];
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkMem(string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== expMem[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic startC();
    sdaM = 1'b1; tick(HALF/2);
    scl = 1'b1;  tick(HALF);
    sdaM = 1'b0; tick(HALF);
    scl = 1'b0;  tick(HALF/2);
  endtask

  task automatic stopC();
    sdaM = 1'b0; tick(HALF/2);
    scl = 1'b1;  tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic clkBit(input logic b, output logic seen);
    sdaM = b;   tick(HALF/2);
    scl = 1'b1; tick(HALF/2);
    seen = sdaLine; tick(HALF/2);
    scl = 1'b0; tick(HALF/2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(b[i], s);
    clkBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      b[i] = s;
    end
    clkBit(~ackIt, s);
  endtask

  task automatic tReset();
    chk("R12 sdaOe after reset", int'(sdaOe), 0);
    chk("R12 memWrEn after reset", int'(memWrEn), 0);
  endtask

  task automatic tNoStart();
    logic a;
    scl = 1'b0; tick(HALF/2);
    sendByte(8'hA0, a);
    chk("R1 byte without START unacked", int'(a), 0);
    stopC();
  endtask

  task automatic tByteWrite();
    logic a;
    startC();
    sendByte(8'hA2, a); chk("R2 valid control acked", int'(a), 1);
    sendByte(8'h35, a); chk("R5 word address acked", int'(a), 1);
    sendByte(8'hA5, a); chk("R3 data ack seen in high phase", int'(a), 1);
    chk("R3 SDA released after ack clock", int'(sdaOe), 0);
    stopC();
    startC();
    sendByte(8'hA2, a); chk("R6 no ack while programming", int'(a), 0);
    stopC();
    tick(PROG + 50);
    startC();
    sendByte(8'hA2, a); chk("R6 ack after programming", int'(a), 1);
    stopC();
    expMem[9'h135] = 8'hA5;
    checkMem("R4 bank one byte write");
  endtask

  task automatic tBankIgnore();
    logic a;
    startC();
    sendByte(8'hAC, a);
    sendByte(8'h10, a);
    sendByte(8'h5A, a);
    stopC();
    tick(PROG + 50);
    expMem[9'h010] = 8'h5A;
    checkMem("R4 upper select bits ignored");
  endtask

  task automatic tPage();
    logic a;
    startC();
    sendByte(8'hA0, a);
    sendByte(8'h2E, a);
    for (int k = 0; k < 18; k++) begin
      sendByte(8'(8'h80 + k), a);
      expMem[9'h020 + ((14 + k) & 15)] = 8'(8'h80 + k);
    end
    stopC();
    tick(PROG + 50);
    checkMem("R5 page wrap keeps last sixteen");
  endtask

  task automatic tWp();
    logic a;
    wp = 1'b1;
    startC();
    sendByte(8'hA0, a);
    sendByte(8'h50, a);
    sendByte(8'hFF, a);
    stopC();
    startC();
    sendByte(8'hA0, a); chk("R7 no programming cycle when protected", int'(a), 1);
    stopC();
    tick(PROG + 50);
    wp = 1'b0;
    checkMem("R7 protected array unchanged");
  endtask

  task automatic tBadCode();
    logic a;
    startC();
    sendByte(8'hB0, a); chk("R2 wrong code unacked", int'(a), 0);
    sendByte(8'hA0, a); chk("R2 rest of command ignored", int'(a), 0);
    stopC();
  endtask

  task automatic tRandomRead();
    logic a;
    logic [7:0] d;
    startC();
    sendByte(8'hA2, a);
    sendByte(8'hFE, a);
    startC();
    sendByte(8'hA3, a); chk("R10 read control after restart acked", int'(a), 1);
    recvByte(1'b1, d); chk("R10 read at restart address", int'(d), int'(expMem[9'h1FE]));
    recvByte(1'b1, d); chk("R8 sequential read", int'(d), int'(expMem[9'h1FF]));
    recvByte(1'b0, d); chk("R8 wrap to address zero", int'(d), int'(expMem[9'h000]));
    chk("R9 SDA released after master nack", int'(sdaOe), 0);
    tick(HALF);
    chk("R9 line high after nack", int'(sdaLine), 1);
    stopC();
    startC();
    sendByte(8'hA1, a);
    recvByte(1'b0, d); chk("R8 current address read", int'(d), int'(expMem[9'h001]));
    stopC();
  endtask

  task automatic tAddrOnly();
    logic a;
    logic [7:0] d;
    startC();
    sendByte(8'hA0, a);
    sendByte(8'h77, a);
    stopC();
    startC();
    sendByte(8'hA1, a); chk("R11 no programming after address only", int'(a), 1);
    recvByte(1'b0, d); chk("R11 address kept", int'(d), int'(expMem[9'h077]));
    stopC();
    checkMem("R11 nothing written");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = initVal(i);
    tick(5);
    rstN = 1'b1;
    tick(3);
    tReset();
    tNoStart();
    tByteWrite();
    tBankIgnore();
    tPage();
    tWp();
    tBadCode();
    tRandomRead();
    tAddrOnly();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule